// File: doc/BRIEF.md
# Twin-Copy Parity-Protected Data Array

This block is the data storage of a cache that must serve two loads in the same cycle. It keeps two identical copies of the array. Load port 0 reads only copy 0 and load port 1 reads only copy 1, so the two reads never compete for a read port. One store port writes both copies together, and a store cycle excludes loads. Each stored byte carries an even parity bit. Partial-word stores need no read-modify-write, because parity is formed byte by byte.

When a load finds bad parity in its own copy, the block parks the load. It reads the same word from the sibling copy and returns that word. If the sibling word checks clean, the block writes it back over the damaged word. It signals each such event on a small error bus. If both copies of the word are bad, the load still completes, but it carries an uncorrectable flag and no repair is made.

A test hook travels with a store. It inverts the stored parity bits of the enabled bytes in one chosen copy, so that detection and repair can be provoked from the ports.

Top module: `twin_data_array`

## Requirements
- R1: After synchronous reset, `ld0_valid`, `ld1_valid`, `err_evt` and `err_uncorr` are 0, and both `ld_ready` and `st_ready` are 1 while no request is pending.
- R2: A load accepted on port N (`ldN_en` high while `ld_ready` is 1) reads copy N. If its parity is clean, `ldN_valid` is high for one cycle, with the stored word, two clock edges after acceptance. Both ports may be accepted in the same cycle.
- R3: A store is accepted when `st_en` and `st_ready` are both 1, and it writes both copies. In that cycle `ld_ready` is 0, and any load request then present is dropped with no valid response.
- R4: Byte lane b is bits 8b+7..8b of the data word. `st_be` bit b enables lane b. Lanes whose enable is 0 keep their previous contents in both copies.
- R5: A load whose own copy has a parity error, while the sibling word is clean, returns the sibling word four edges after acceptance. In that same cycle `err_evt` is 1, `err_copy` equals the port number, and `err_uncorr` is 0.
- R6: After a corrected load, the damaged word has been rewritten. The next load of that address on the same port completes in two edges and raises no event.
- R7: From the cycle in which a parity error is seen until the cycle the repair is written, both `st_ready` and `ld_ready` are 0.
- R8: When both copies of a word are bad, the load still completes on the recovery schedule with `err_evt` and `err_uncorr` both 1. No repair is written, so a repeated load reports the same.
- R9: When both ports see parity errors in the same cycle, port 0 is recovered first (four edges) and port 1 second (six edges). Each recovery raises its own `err_evt` pulse.
- R10: A store with `inj_en` high inverts the stored parity bit of every enabled lane in copy `inj_copy` only. The other copy is written normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld0_en | input | 1 | Load request, port 0 |
| ld0_addr | input | ADDR_W | Load word address, port 0 |
| ld1_en | input | 1 | Load request, port 1 |
| ld1_addr | input | ADDR_W | Load word address, port 1 |
| ld_ready | output | 1 | Load requests are accepted this cycle |
| ld0_valid | output | 1 | Load result valid, port 0 |
| ld0_data | output | 8*BYTES | Load result data, port 0 |
| ld1_valid | output | 1 | Load result valid, port 1 |
| ld1_data | output | 8*BYTES | Load result data, port 1 |
| st_en | input | 1 | Store request |
| st_addr | input | ADDR_W | Store word address |
| st_data | input | 8*BYTES | Store data |
| st_be | input | BYTES | Store byte-lane enables |
| st_ready | output | 1 | A store is accepted this cycle |
| inj_en | input | 1 | Corrupt parity of this store in one copy |
| inj_copy | input | 1 | Copy that receives the corrupted parity |
| err_evt | output | 1 | One-cycle pulse: a parity-error load completes |
| err_copy | output | 1 | Port (equal to copy) whose word was bad |
| err_uncorr | output | 1 | Both copies were bad; data not trustworthy |

## Verification
The hardest conditions to reach are the double-fault cases: a word bad in both copies, and both ports faulting in the same cycle. Parity can only be damaged through a store, and every store rewrites both copies. The bench therefore lays down faults with two partial stores that hit different lanes, injecting into copy 0 on one and copy 1 on the other. It also faults two different addresses before a paired load. Random traffic then confines addresses to a small window with frequent injecting stores. This makes repaired, re-damaged and doubly-damaged words recur, and a reference model of per-lane damage per copy predicts each outcome.

// File: rtl/twin_pkg.sv
package twin_pkg;
  localparam int LANE_W      = 8;
  localparam int LANE_CODE_W = LANE_W + 1;

  typedef enum logic [1:0] {
    RS_IDLE   = 2'd0,
    RS_XREAD  = 2'd1,
    RS_XCHECK = 2'd2
  } rec_state_e;
endpackage

// File: rtl/twin_lane_code.sv
module twin_lane_code
  import twin_pkg::*;
#(
  parameter int BYTES = 4
) (
  input  logic [BYTES*LANE_W-1:0]      data,
  output logic [BYTES*LANE_CODE_W-1:0] code
);
  for (genvar b = 0; b < BYTES; b++) begin : g_lane
    // even parity: the extra bit makes the nine-bit lane have an even count of ones
    assign code[b*LANE_CODE_W +: LANE_CODE_W] =
      {^data[b*LANE_W +: LANE_W], data[b*LANE_W +: LANE_W]};
  end
endmodule

// File: rtl/twin_lane_check.sv
module twin_lane_check
  import twin_pkg::*;
#(
  parameter int BYTES = 4
) (
  input  logic [BYTES*LANE_CODE_W-1:0] code,
  output logic [BYTES*LANE_W-1:0]      data,
  output logic [BYTES-1:0]             bad
);
  for (genvar b = 0; b < BYTES; b++) begin : g_lane
    assign data[b*LANE_W +: LANE_W] = code[b*LANE_CODE_W +: LANE_W];
    assign bad[b] = ^code[b*LANE_CODE_W +: LANE_CODE_W];
  end
endmodule

// File: rtl/twin_bank.sv
module twin_bank
  import twin_pkg::*;
#(
  parameter int WORDS  = 64,
  parameter int BYTES  = 4,
  parameter int ADDR_W = 6
) (
  input  logic                         clk,
  input  logic                         we,
  input  logic [BYTES-1:0]             wbe,
  input  logic [ADDR_W-1:0]            waddr,
  input  logic [BYTES*LANE_CODE_W-1:0] wcode,
  input  logic                         re,
  input  logic [ADDR_W-1:0]            raddr,
  output logic [BYTES*LANE_CODE_W-1:0] rcode
);
  // one simple dual-port memory per lane so byte enables map onto RAM write enables
  for (genvar b = 0; b < BYTES; b++) begin : g_lane
    logic [LANE_CODE_W-1:0] mem [WORDS];
    logic [LANE_CODE_W-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (we && wbe[b]) mem[waddr] <= wcode[b*LANE_CODE_W +: LANE_CODE_W];
      if (re) rd_q <= mem[raddr];
    end

    assign rcode[b*LANE_CODE_W +: LANE_CODE_W] = rd_q;
  end
endmodule

// File: rtl/twin_data_array.sv
module twin_data_array
  import twin_pkg::*;
#(
  parameter int WORDS = 64,
  parameter int BYTES = 4,
  localparam int ADDR_W = $clog2(WORDS),
  localparam int DATA_W = BYTES * LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld0_en,
  input  logic [ADDR_W-1:0] ld0_addr,
  input  logic              ld1_en,
  input  logic [ADDR_W-1:0] ld1_addr,
  output logic              ld_ready,
  output logic              ld0_valid,
  output logic [DATA_W-1:0] ld0_data,
  output logic              ld1_valid,
  output logic [DATA_W-1:0] ld1_data,
  input  logic              st_en,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [DATA_W-1:0] st_data,
  input  logic [BYTES-1:0]  st_be,
  output logic              st_ready,
  input  logic              inj_en,
  input  logic              inj_copy,
  output logic              err_evt,
  output logic              err_copy,
  output logic              err_uncorr
);
  localparam int CODE_W = BYTES * LANE_CODE_W;

  function automatic logic [CODE_W-1:0] parity_positions();
    logic [CODE_W-1:0] m;
    m = '0;
    for (int b = 0; b < BYTES; b++) m[b*LANE_CODE_W + LANE_W] = 1'b1;
    return m;
  endfunction

  localparam logic [CODE_W-1:0] PAR_MASK = parity_positions();

  rec_state_e        state;
  logic              rec_port;
  logic [1:0]        pend;
  logic [ADDR_W-1:0] pend_addr [2];
  logic [ADDR_W-1:0] rec_addr;
  logic [ADDR_W-1:0] lq_addr [2];
  logic [1:0]        rvld;
  logic [1:0]        bad_any;
  logic [CODE_W-1:0] rd_code [2];
  logic [DATA_W-1:0] rd_data [2];
  logic [1:0]        ld_en_v;
  logic [ADDR_W-1:0] ld_addr_v [2];
  logic [1:0]        ld_go;
  logic [1:0]        vld_q;
  logic [DATA_W-1:0] data_q [2];
  logic [CODE_W-1:0] st_code;
  logic              idle, err_now, st_ok, ld_ok, st_go, in_xcheck, in_xread;

  assign ld_en_v      = {ld1_en, ld0_en};
  assign ld_addr_v[0] = ld0_addr;
  assign ld_addr_v[1] = ld1_addr;
  assign rec_addr     = pend_addr[rec_port];

  always_comb begin
    idle      = (state == RS_IDLE);
    in_xread  = (state == RS_XREAD);
    in_xcheck = (state == RS_XCHECK);
    err_now   = |(rvld & bad_any);
    st_ok     = idle && !err_now;
    st_go     = st_en && st_ok;
    ld_ok     = st_ok && !st_en;
    ld_go     = ld_en_v & {2{ld_ok}};
  end

  assign ld_ready = ld_ok;
  assign st_ready = st_ok;

  twin_lane_code #(.BYTES(BYTES)) i_enc (
    .data (st_data),
    .code (st_code)
  );

  for (genvar c = 0; c < 2; c++) begin : g_copy
    localparam int OTH = 1 - c;
    logic              wr_en;
    logic [BYTES-1:0]  wr_be;
    logic [ADDR_W-1:0] wr_addr;
    logic [CODE_W-1:0] wr_code;
    logic              rd_en;
    logic [ADDR_W-1:0] rd_addr;
    logic [BYTES-1:0]  lane_bad;

    // repair write-back has the write port during the check cycle of a recovery
    always_comb begin
      if (in_xcheck && (rec_port == c[0]) && !bad_any[OTH]) begin
        wr_en   = 1'b1;
        wr_be   = '1;
        wr_addr = rec_addr;
        wr_code = rd_code[OTH];
      end else begin
        wr_en   = st_go;
        wr_be   = st_be;
        wr_addr = st_addr;
        wr_code = (inj_en && (inj_copy == c[0])) ? (st_code ^ PAR_MASK) : st_code;
      end
      rd_en   = ld_go[c] || (in_xread && (rec_port != c[0]));
      rd_addr = in_xread ? rec_addr : ld_addr_v[c];
    end

    twin_bank #(.WORDS(WORDS), .BYTES(BYTES), .ADDR_W(ADDR_W)) i_bank (
      .clk   (clk),
      .we    (wr_en),
      .wbe   (wr_be),
      .waddr (wr_addr),
      .wcode (wr_code),
      .re    (rd_en),
      .raddr (rd_addr),
      .rcode (rd_code[c])
    );

    twin_lane_check #(.BYTES(BYTES)) i_chk (
      .code (rd_code[c]),
      .data (rd_data[c]),
      .bad  (lane_bad)
    );

    assign bad_any[c] = |lane_bad;

    always_ff @(posedge clk) begin
      if (ld_go[c]) lq_addr[c] <= ld_addr_v[c];
      if (idle && err_now) pend_addr[c] <= lq_addr[c];
      data_q[c] <= (in_xcheck && (rec_port == c[0])) ? rd_data[OTH] : rd_data[c];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= RS_IDLE;
      rec_port   <= 1'b0;
      pend       <= '0;
      rvld       <= '0;
      vld_q      <= '0;
      err_evt    <= 1'b0;
      err_copy   <= 1'b0;
      err_uncorr <= 1'b0;
    end else begin
      rvld <= ld_go;
      for (int c = 0; c < 2; c++) begin
        vld_q[c] <= (rvld[c] && !bad_any[c]) || (in_xcheck && (rec_port == c[0]));
      end
      err_evt    <= in_xcheck;
      err_copy   <= rec_port;
      err_uncorr <= in_xcheck && bad_any[~rec_port];
      unique case (state)
        RS_IDLE: begin
          if (err_now) begin
            pend     <= rvld & bad_any;
            rec_port <= !(rvld[0] && bad_any[0]);
            state    <= RS_XREAD;
          end
        end
        RS_XREAD: state <= RS_XCHECK;
        RS_XCHECK: begin
          pend[rec_port] <= 1'b0;
          if (pend[~rec_port]) begin
            rec_port <= ~rec_port;
            state    <= RS_XREAD;
          end else begin
            state <= RS_IDLE;
          end
        end
        default: state <= RS_IDLE;
      endcase
    end
  end

  assign ld0_valid = vld_q[0];
  assign ld1_valid = vld_q[1];
  assign ld0_data  = data_q[0];
  assign ld1_data  = data_q[1];
endmodule

// File: rtl/twin_data_array_chk.sv
module twin_data_array_chk (
  input logic clk,
  input logic rst,
  input logic ld_ready,
  input logic st_en,
  input logic st_ready,
  input logic ld0_valid,
  input logic ld1_valid,
  input logic err_evt,
  input logic err_copy,
  input logic err_uncorr
);
  // R3: an accepted store leaves no load slot in the same cycle
  a_r3_store_excludes_loads: assert property (@(posedge clk) disable iff (rst)
    (st_en && st_ready) |-> !ld_ready);

  // R7: the cycle before a recovery completes, stores are held off
  a_r7_recovery_holds_store: assert property (@(posedge clk) disable iff (rst)
    err_evt |-> $past(!st_ready));

  // R7: loads are never open while stores are closed
  a_r7_load_open_needs_store_open: assert property (@(posedge clk) disable iff (rst)
    ld_ready |-> st_ready);

  // R5: every error event comes with the result of the affected port
  a_r5_event_has_result: assert property (@(posedge clk) disable iff (rst)
    err_evt |-> (err_copy ? ld1_valid : ld0_valid));

  // R8: the uncorrectable flag only qualifies an event
  a_r8_uncorr_inside_event: assert property (@(posedge clk) disable iff (rst)
    err_uncorr |-> err_evt);

  // R9: back-to-back recoveries are separated by the cross-read cycle
  a_r9_events_spaced: assert property (@(posedge clk) disable iff (rst)
    err_evt |=> !err_evt);
endmodule

bind twin_data_array twin_data_array_chk i_twin_chk (
  .clk        (clk),
  .rst        (rst),
  .ld_ready   (ld_ready),
  .st_en      (st_en),
  .st_ready   (st_ready),
  .ld0_valid  (ld0_valid),
  .ld1_valid  (ld1_valid),
  .err_evt    (err_evt),
  .err_copy   (err_copy),
  .err_uncorr (err_uncorr)
);

// File: tb/test_twin_data_array.sv
module test_twin_data_array;
  localparam int WORDS = 64;
  localparam int BYTES = 4;
  localparam int AW    = 6;
  localparam int DW    = 32;
  localparam int SPAN  = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ld0_en = 0, ld1_en = 0;
  logic [AW-1:0] ld0_addr = '0, ld1_addr = '0;
  logic          ld_ready, ld0_valid, ld1_valid;
  logic [DW-1:0] ld0_data, ld1_data;
  logic          st_en = 0;
  logic [AW-1:0] st_addr = '0;
  logic [DW-1:0] st_data = '0;
  logic [3:0]    st_be = '0;
  logic          st_ready;
  logic          inj_en = 0, inj_copy = 0;
  logic          err_evt, err_copy, err_uncorr;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit done  = 0;

  logic [DW-1:0] ref_data [SPAN];
  logic [3:0]    ref_bad0 [SPAN];
  logic [3:0]    ref_bad1 [SPAN];

  always #10 clk = ~clk;

  twin_data_array #(.WORDS(WORDS), .BYTES(BYTES)) i_twin_data_array (
    .clk(clk), .rst(rst),
    .ld0_en(ld0_en), .ld0_addr(ld0_addr), .ld1_en(ld1_en), .ld1_addr(ld1_addr),
    .ld_ready(ld_ready),
    .ld0_valid(ld0_valid), .ld0_data(ld0_data), .ld1_valid(ld1_valid), .ld1_data(ld1_data),
    .st_en(st_en), .st_addr(st_addr), .st_data(st_data), .st_be(st_be), .st_ready(st_ready),
    .inj_en(inj_en), .inj_copy(inj_copy),
    .err_evt(err_evt), .err_copy(err_copy), .err_uncorr(err_uncorr)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old, input logic [DW-1:0] nw,
                                          input logic [3:0] be);
    logic [DW-1:0] r = old;
    for (int b = 0; b < BYTES; b++) if (be[b]) r[b*8 +: 8] = nw[b*8 +: 8];
    return r;
  endfunction

  task automatic do_store(input int a, input logic [DW-1:0] d, input logic [3:0] be,
                          input bit inj, input bit icopy);
    @(negedge clk);
    chk(st_ready === 1'b1, "R3", "st_ready before store", 64'(st_ready), 64'd1);
    st_en = 1; st_addr = AW'(a); st_data = d; st_be = be; inj_en = inj; inj_copy = icopy;
    #1;
    chk(ld_ready === 1'b0, "R3", "ld_ready during store", 64'(ld_ready), 64'd0);
    @(negedge clk);
    st_en = 0; inj_en = 0;
    ref_data[a] = merge(ref_data[a], d, be);
    for (int b = 0; b < BYTES; b++) begin
      if (be[b]) begin
        ref_bad0[a][b] = inj && !icopy;
        ref_bad1[a][b] = inj && icopy;
      end
    end
  endtask

  task automatic do_load(input bit e0, input int a0, input bit e1, input int a1);
    bit err0, err1, unc0, unc1, anyerr;
    int lat0, lat1, seen0, seen1, nevt, exp_evt;
    logic [DW-1:0] got0, got1;
    err0 = e0 && (ref_bad0[a0] != 0);
    err1 = e1 && (ref_bad1[a1] != 0);
    anyerr = err0 || err1;
    unc0 = 0; unc1 = 0;
    lat0 = err0 ? 4 : 2;
    lat1 = err1 ? (err0 ? 6 : 4) : 2;
    if (err0) begin
      if (ref_bad1[a0] == 0) ref_bad0[a0] = 0; else unc0 = 1;
    end
    if (err1) begin
      if (ref_bad0[a1] == 0) ref_bad1[a1] = 0; else unc1 = 1;
    end
    exp_evt = int'(err0) + int'(err1);
    seen0 = 0; seen1 = 0; nevt = 0; got0 = '0; got1 = '0;
    @(negedge clk);
    chk(ld_ready === 1'b1, "R2", "ld_ready before load", 64'(ld_ready), 64'd1);
    ld0_en = e0; ld0_addr = AW'(a0); ld1_en = e1; ld1_addr = AW'(a1);
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      if (k == 1) begin
        ld0_en = 0; ld1_en = 0;
        if (anyerr) begin
          chk(st_ready === 1'b0, "R7", "st_ready at detection", 64'(st_ready), 64'd0);
          chk(ld_ready === 1'b0, "R7", "ld_ready at detection", 64'(ld_ready), 64'd0);
        end
      end
      if (k == 3 && anyerr)
        chk(st_ready === 1'b0, "R7", "st_ready at repair", 64'(st_ready), 64'd0);
      if (ld0_valid && seen0 == 0) begin seen0 = k; got0 = ld0_data; end
      if (ld1_valid && seen1 == 0) begin seen1 = k; got1 = ld1_data; end
      if (err_evt) begin
        if (nevt == 0) begin
          chk(err_copy === (err0 ? 1'b0 : 1'b1), "R5", "err_copy first event",
              64'(err_copy), 64'(!err0));
          chk(err_uncorr === (err0 ? unc0 : unc1), "R8", "err_uncorr first event",
              64'(err_uncorr), 64'(err0 ? unc0 : unc1));
        end else begin
          chk(err_copy === 1'b1, "R9", "err_copy second event", 64'(err_copy), 64'd1);
          chk(err_uncorr === unc1, "R8", "err_uncorr second event", 64'(err_uncorr), 64'(unc1));
        end
        nevt++;
      end
    end
    chk(nevt == exp_evt, anyerr ? "R9" : "R6", "error event count", 64'(nevt), 64'(exp_evt));
    if (e0) begin
      chk(seen0 == lat0, err0 ? "R5" : "R2", "port0 latency", 64'(seen0), 64'(lat0));
      chk(got0 === ref_data[a0], err0 ? "R5" : "R2", "port0 data", 64'(got0), 64'(ref_data[a0]));
    end else begin
      chk(seen0 == 0, "R2", "port0 idle", 64'(seen0), 64'd0);
    end
    if (e1) begin
      chk(seen1 == lat1, err1 ? "R9" : "R2", "port1 latency", 64'(seen1), 64'(lat1));
      chk(got1 === ref_data[a1], err1 ? "R5" : "R2", "port1 data", 64'(got1), 64'(ref_data[a1]));
    end else begin
      chk(seen1 == 0, "R2", "port1 idle", 64'(seen1), 64'd0);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int a = 0; a < SPAN; a++) begin
      ref_data[a] = '0; ref_bad0[a] = '0; ref_bad1[a] = '0;
    end
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset state
    chk(ld0_valid === 1'b0 && ld1_valid === 1'b0, "R1", "valids after reset",
        64'({ld1_valid, ld0_valid}), 64'd0);
    chk(err_evt === 1'b0 && err_uncorr === 1'b0, "R1", "error outputs after reset",
        64'({err_evt, err_uncorr}), 64'd0);
    chk(ld_ready === 1'b1 && st_ready === 1'b1, "R1", "ready after reset",
        64'({ld_ready, st_ready}), 64'd3);

    for (int a = 0; a < SPAN; a++) do_store(a, $urandom, 4'hF, 0, 0);

    // R2: both ports in one cycle, different addresses
    do_load(1, 2, 1, 11);
    do_load(1, 4, 0, 0);
    do_load(0, 0, 1, 4);

    // R4: partial store keeps the lanes not enabled
    do_store(3, 32'hA5C3_7E19, 4'b0101, 0, 0);
    do_load(1, 3, 1, 3);

    // R3: loads presented with a store are dropped
    @(negedge clk);
    st_en = 1; st_addr = AW'(1); st_data = 32'h1357_9BDF; st_be = 4'hF;
    ld0_en = 1; ld1_en = 1; ld0_addr = AW'(1); ld1_addr = AW'(1);
    @(negedge clk);
    st_en = 0; ld0_en = 0; ld1_en = 0;
    ref_data[1] = 32'h1357_9BDF;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(ld0_valid === 1'b0 && ld1_valid === 1'b0, "R3", "load during store dropped",
          64'({ld1_valid, ld0_valid}), 64'd0);
    end
    do_load(1, 1, 1, 1);

    // R10 + R5: corrupt copy 0 only, port 1 reads clean, port 0 corrected
    do_store(5, 32'hDEAD_BEEF, 4'hF, 1, 0);
    do_load(0, 0, 1, 5);
    do_load(1, 5, 0, 0);
    // R6: repaired word now reads clean
    do_load(1, 5, 0, 0);
    // R5: corrupt copy 1, port 1 corrected
    do_store(6, 32'h0F0F_F0F0, 4'b1000, 1, 1);
    do_load(1, 6, 1, 6);

    // R8: lane 0 bad in copy 0, lane 1 bad in copy 1
    do_store(7, 32'h1122_3344, 4'b0001, 1, 0);
    do_store(7, 32'h1122_3344, 4'b0010, 1, 1);
    do_load(1, 7, 0, 0);
    do_load(1, 7, 1, 7);

    // R9: both ports fault in the same cycle
    do_store(8, 32'hCAFE_0001, 4'hF, 1, 0);
    do_store(9, 32'hCAFE_0002, 4'hF, 1, 1);
    do_load(1, 8, 1, 9);

    // random traffic over a small address window
    for (int i = 0; i < 500; i++) begin
      int op;
      op = int'($urandom % 4);
      if (op == 0) begin
        do_store(int'($urandom % SPAN), $urandom, 4'($urandom),
                 ($urandom % 3) == 0, 1'($urandom));
      end else begin
        do_load(1'($urandom), int'($urandom % SPAN), 1'($urandom), int'($urandom % SPAN));
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule